// File: doc/BRIEF.md
# Pipelined Late-Write Burst Static Memory

A single-port synchronous word memory intended as a fast data store behind a cache controller. The host issues a transfer by pulsing a start input with the first word address and a read/write flag. The block then walks four consecutive word addresses by itself, so the host never presents the later ones. The address counter wraps inside the low two address bits and leaves the upper bits alone.

Writes follow a late-write rule: each write beat's data is sampled one clock after the edge that produced that beat's address. The block holds the sampled word in a holding register and commits it to the array on the following edge, so no external write pulse is needed. If a read reaches the array while a committed-late word is still in the holding register for the same address, the held word is forwarded to the read. Read data travels through an array output register and a short pipeline, so it reaches the pins a fixed three edges after its address edge.

Alongside each read beat the block raises its own output enable and steps two data strobes, each with a complement, so a receiver can latch the word. The word width is set by `DATA_W` (36 by default). The depth is 2^`ADDR_W` words. `ADDR_W` = 16 gives 64K words; the default build uses `ADDR_W` = 10.

Top module: `lw_burst_sram`

## Requirements
- R1: While `rst_n` is low and on the edge after it is sampled low, `rdata_oe_o` is 0, `rdata_o` is all zero, `strb_a_o` and `strb_b_o` are 0, and `strb_a_n_o` and `strb_b_n_o` are 1.
- R2: A read burst whose `start_i` is sampled at edge N drives beat k (k = 0..3) on `rdata_o` with `rdata_oe_o` = 1 in the cycle that follows edge N+3+k.
- R3: A burst has exactly four beats. Beat k uses the address whose low two bits are (base low bits + k) mod 4 and whose upper bits equal those of the base address (base 2 gives 2,3,0,1).
- R4: For a write burst (`we_i` = 1 with `start_i`) sampled at edge N, the word on `wdata_i` at edge N+1+k is stored at the address of beat k.
- R5: `rdata_oe_o` is 1 only in cycles that carry a read beat, never because of a write beat. `rdata_o` is all zero whenever `rdata_oe_o` is 0.
- R6: In every cycle that carries a read beat, `strb_a_o` and `strb_b_o` both take the inverse of their previous level. In all other cycles they hold their level. `strb_a_n_o` and `strb_b_n_o` are always the inverses of `strb_a_o` and `strb_b_o`.
- R7: A read beat whose address equals a write beat that was accepted one cycle earlier returns that write's new data.
- R8: A `start_i` sampled while a burst is running ends that burst. Its remaining beats neither read nor write, and the new burst's beat 0 follows at once.
- R9: Reset clears the burst state and the read pipeline, so no beat of an interrupted read reaches the outputs. Words already written to the array keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a four-beat burst at `addr_i` |
| we_i | input | 1 | 1 = write burst, 0 = read burst; sampled with `start_i` |
| addr_i | input | ADDR_W | First word address of the burst |
| wdata_i | input | DATA_W | Write data, sampled one edge after each write beat's address |
| rdata_o | output | DATA_W | Read data, zero when not enabled |
| rdata_oe_o | output | 1 | High while `rdata_o` carries a valid read beat |
| strb_a_o | output | 1 | Data strobe A, changes level with each read beat |
| strb_a_n_o | output | 1 | Complement of strobe A |
| strb_b_o | output | 1 | Data strobe B, changes level with each read beat |
| strb_b_n_o | output | 1 | Complement of strobe B |

## Verification
The bound checker watches every cycle for several properties: the fixed distance between an internal read beat and the output enable, the absence of output enable for write beats, the stepping and holding of both strobes and their complements, the burst length, and the in-burst address stepping with fixed upper bits. Whether the stored and returned words are the right ones cannot be seen by any single-cycle property. That includes late-write placement, the wrap order, forwarding from the holding register, the abort of a burst by a restart, and array contents surviving a reset. Only the bench's scenarios show these, by comparing each beat against its own memory model.

// File: rtl/lwb_pkg.sv
`timescale 1ns/1ps
package lwb_pkg;
  // direction of the burst currently being walked
  typedef enum logic {
    OP_RD = 1'b0,
    OP_WR = 1'b1
  } op_e;
endpackage

// File: rtl/lwb_burst_ctl.sv
`timescale 1ns/1ps
// Input registers and the wrapping beat counter.
module lwb_burst_ctl
  import lwb_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              beat_v_o,
  output op_e               beat_op_o,
  output logic [ADDR_W-1:0] beat_addr_o
);
  localparam int CNT_W = $clog2(BURST_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST_LEN - 1);

  logic             act_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  op_e              op_q,  op_d;
  logic [ADDR_W-1:0] base_q;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    op_d  = op_q;
    if (start_i) begin
      // a new start always wins over a running burst
      act_d = 1'b1;
      cnt_d = '0;
      op_d  = op_i;
    end else if (act_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      op_q  <= OP_RD;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
      op_q  <= op_d;
    end
  end

  always_ff @(posedge clk) begin
    if (start_i) base_q <= addr_i;
  end

  assign beat_v_o    = act_q;
  assign beat_op_o   = op_q;
  assign beat_addr_o = {base_q[ADDR_W-1:CNT_W], base_q[CNT_W-1:0] + cnt_q};
endmodule

// File: rtl/lwb_array.sv
`timescale 1ns/1ps
// Storage array, late-write holding register and read forwarding.
module lwb_array
  import lwb_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_v_i,
  input  op_e               beat_op_i,
  input  logic [ADDR_W-1:0] beat_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rd_v_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              wv_q, rv_q;
  logic [ADDR_W-1:0] wa_q;
  logic [DATA_W-1:0] wd_q, rd_q;
  logic              wr_cap, rd_req, fwd;
  logic [DATA_W-1:0] rd_nxt;

  always_comb begin
    wr_cap = beat_v_i && (beat_op_i == OP_WR);
    rd_req = beat_v_i && (beat_op_i == OP_RD);
    fwd    = wv_q && (wa_q == beat_addr_i);
    rd_nxt = fwd ? wd_q : mem[beat_addr_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wv_q <= 1'b0;
      rv_q <= 1'b0;
    end else begin
      wv_q <= wr_cap;
      rv_q <= rd_req;
    end
  end

  // data path registers carry enables and no reset
  always_ff @(posedge clk) begin
    if (wr_cap) begin
      wa_q <= beat_addr_i;
      wd_q <= wdata_i;
    end
    if (rd_req) rd_q <= rd_nxt;
  end

  always_ff @(posedge clk) begin
    if (wv_q) mem[wa_q] <= wd_q;
  end

  assign rd_v_o    = rv_q;
  assign rd_data_o = rd_q;
endmodule

// File: rtl/lwb_rd_pipe.sv
`timescale 1ns/1ps
// Read delay chain, output enable and strobe toggle.
module lwb_rd_pipe #(
  parameter int DATA_W = 36,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v_i,
  input  logic [DATA_W-1:0] d_i,
  output logic              oe_o,
  output logic [DATA_W-1:0] data_o,
  output logic              strb_o
);
  logic              vc [STAGES+1];
  logic [DATA_W-1:0] dc [STAGES+1];
  logic              tgl_q, tgl_d;

  assign vc[0] = v_i;
  assign dc[0] = d_i;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic              v_q;
    logic [DATA_W-1:0] d_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= vc[i];
    end

    always_ff @(posedge clk) begin
      if (vc[i]) d_q <= dc[i];
    end

    assign vc[i+1] = v_q;
    assign dc[i+1] = d_q;
  end

  // strobe steps on the edge that loads a beat into the last stage
  assign tgl_d = tgl_q ^ vc[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgl_q <= 1'b0;
    else        tgl_q <= tgl_d;
  end

  assign oe_o   = vc[STAGES];
  assign data_o = vc[STAGES] ? dc[STAGES] : '0;
  assign strb_o = tgl_q;
endmodule

// File: rtl/lw_burst_sram.sv
`timescale 1ns/1ps
// Pipelined late-write burst memory, top level.
module lw_burst_sram
  import lwb_pkg::*;
#(
  parameter int DATA_W    = 36,
  parameter int ADDR_W    = 10,
  parameter int BURST_LEN = 4,
  parameter int RD_LAT    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  output logic              strb_a_o,
  output logic              strb_a_n_o,
  output logic              strb_b_o,
  output logic              strb_b_n_o
);
  localparam int PIPE_STAGES = RD_LAT - 1;

  op_e               op_in;
  logic              beat_v;
  op_e               beat_op;
  logic [ADDR_W-1:0] beat_addr;
  logic              arr_v;
  logic [DATA_W-1:0] arr_data;
  logic              strb;

  assign op_in = we_i ? OP_WR : OP_RD;

  lwb_burst_ctl #(
    .ADDR_W   (ADDR_W),
    .BURST_LEN(BURST_LEN)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .op_i       (op_in),
    .addr_i     (addr_i),
    .beat_v_o   (beat_v),
    .beat_op_o  (beat_op),
    .beat_addr_o(beat_addr)
  );

  lwb_array #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_arr (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_v_i   (beat_v),
    .beat_op_i  (beat_op),
    .beat_addr_i(beat_addr),
    .wdata_i    (wdata_i),
    .rd_v_o     (arr_v),
    .rd_data_o  (arr_data)
  );

  lwb_rd_pipe #(
    .DATA_W(DATA_W),
    .STAGES(PIPE_STAGES)
  ) u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .v_i   (arr_v),
    .d_i   (arr_data),
    .oe_o  (rdata_oe_o),
    .data_o(rdata_o),
    .strb_o(strb)
  );

  assign strb_a_o   = strb;
  assign strb_b_o   = strb;
  assign strb_a_n_o = ~strb;
  assign strb_b_n_o = ~strb;
endmodule

// File: rtl/lwb_checker.sv
`timescale 1ns/1ps
module lwb_checker
  import lwb_pkg::*;
#(
  parameter int DATA_W    = 36,
  parameter int ADDR_W    = 10,
  parameter int BURST_LEN = 4,
  parameter int RD_LAT    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              beat_v,
  input op_e               beat_op,
  input logic [ADDR_W-1:0] beat_addr,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rdata_oe_o,
  input logic              strb_a_o,
  input logic              strb_a_n_o,
  input logic              strb_b_o,
  input logic              strb_b_n_o
);
  localparam int CNT_W = $clog2(BURST_LEN);
  localparam int RUN_W = CNT_W + 1;

  logic [RD_LAT-1:0] rd_hist_q;
  logic              st_q;
  logic [RUN_W-1:0]  run_q;

  // read beats seen at the array input, delayed by the read latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_hist_q <= '0;
      st_q      <= 1'b0;
      run_q     <= '0;
    end else begin
      rd_hist_q <= {rd_hist_q[RD_LAT-2:0], beat_v && (beat_op == OP_RD)};
      st_q      <= start_i;
      if (beat_v) run_q <= st_q ? RUN_W'(1) : run_q + 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!rdata_oe_o && rdata_o == '0 && !strb_a_o && !strb_b_o));

  assert_rd_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hist_q[RD_LAT-1] |-> rdata_oe_o);

  assert_oe_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe_o |-> rd_hist_q[RD_LAT-1]);

  assert_start_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_q |-> beat_v);

  assert_burst_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_v && !st_q) |-> (run_q < RUN_W'(BURST_LEN)));

  assert_burst_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_v && $past(beat_v) && !st_q) |->
      (beat_addr[ADDR_W-1:CNT_W] == $past(beat_addr[ADDR_W-1:CNT_W]) &&
       beat_addr[CNT_W-1:0] == CNT_W'($past(beat_addr[CNT_W-1:0]) + 1'b1)));

  assert_strobe_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe_o |-> !$stable(strb_a_o));

  assert_strobe_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe_o |-> $stable(strb_a_o));

  assert_strobe_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_b_o == strb_a_o) && (strb_a_n_o == !strb_a_o) && (strb_b_n_o == !strb_b_o));
endmodule

bind lw_burst_sram lwb_checker #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .BURST_LEN(BURST_LEN),
  .RD_LAT   (RD_LAT)
) u_lwb_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .beat_v    (beat_v),
  .beat_op   (beat_op),
  .beat_addr (beat_addr),
  .rdata_o   (rdata_o),
  .rdata_oe_o(rdata_oe_o),
  .strb_a_o  (strb_a_o),
  .strb_a_n_o(strb_a_n_o),
  .strb_b_o  (strb_b_o),
  .strb_b_n_o(strb_b_n_o)
);

// File: tb/lw_burst_sram_bench.sv
`timescale 1ns/1ps
module lw_burst_sram_bench;
  localparam int DW = 36;
  localparam int AW = 10;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic          we_i;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] wdata_i;
  logic [DW-1:0] rdata_o;
  logic          rdata_oe_o;
  logic          strb_a_o, strb_a_n_o, strb_b_o, strb_b_n_o;

  lw_burst_sram #(.DATA_W(DW), .ADDR_W(AW)) u_lw_burst_sram (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .rdata_oe_o(rdata_oe_o), .strb_a_o(strb_a_o), .strb_a_n_o(strb_a_n_o),
    .strb_b_o(strb_b_o), .strb_b_n_o(strb_b_n_o)
  );

  typedef struct {
    int            due;
    logic [DW-1:0] data;
    string         req;
  } exp_t;

  exp_t          exp_q[$];
  exp_t          cur;
  logic [DW-1:0] mdl [int];
  logic          exp_strb;
  int            cyc;
  int            n_cmp;
  int            n_bad;
  bit            done;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int beat_addr(input int base, input int k);
    return (base & ~3) | ((base + k) & 3);
  endfunction

  function automatic logic [DW-1:0] val(input int seed, input int k);
    return {4'(seed + k), 32'(seed * 32'h9E37 + k * 32'h1111)};
  endfunction

  // read burst: push the four expected beats, start sampled at the next edge
  task automatic rd_burst(input int base, input string req);
    int c;
    c = cyc;
    start_i = 1'b1;
    we_i    = 1'b0;
    addr_i  = AW'(base);
    for (int k = 0; k < 4; k++) begin
      exp_t e;
      e.due  = c + 4 + k;
      e.data = mdl[beat_addr(base, k)];
      e.req  = req;
      exp_q.push_back(e);
    end
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // write burst of nb data beats; returns at the negedge that drove the last one
  task automatic wr_burst(input int base, input int nb, input int seed);
    start_i = 1'b1;
    we_i    = 1'b1;
    addr_i  = AW'(base);
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < nb; k++) begin
      wdata_i = val(seed, k);
      mdl[beat_addr(base, k)] = val(seed, k);
      if (k < nb - 1) @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (exp_q.size() != 0 && exp_q[0].due == cyc) begin
        cur = exp_q.pop_front();
        exp_strb = !exp_strb;
        chk({cur.req, " R2 oe"}, 64'(rdata_oe_o), 64'd1);
        chk({cur.req, " data"}, 64'(rdata_o), 64'(cur.data));
        chk("R6 strobe A step", 64'(strb_a_o), 64'(exp_strb));
        chk("R6 strobe B step", 64'(strb_b_o), 64'(exp_strb));
        chk("R6 strobe A_n", 64'(strb_a_n_o), 64'(!exp_strb));
        chk("R6 strobe B_n", 64'(strb_b_n_o), 64'(!exp_strb));
      end else begin
        chk("R5 oe idle", 64'(rdata_oe_o), 64'd0);
        chk("R5 rdata idle", 64'(rdata_o), 64'd0);
        chk("R6 strobe A hold", 64'(strb_a_o), 64'(exp_strb));
        chk("R6 strobe B hold", 64'(strb_b_o), 64'(exp_strb));
      end
    end
  end

  initial begin
    rst_n    = 1'b0;
    start_i  = 1'b0;
    we_i     = 1'b0;
    addr_i   = '0;
    wdata_i  = '0;
    exp_strb = 1'b0;
    cyc      = 0;
    n_cmp    = 0;
    n_bad    = 0;
    done     = 1'b0;
    idle(3);
    // R1 reset state
    chk("R1 oe in reset", 64'(rdata_oe_o), 64'd0);
    chk("R1 rdata in reset", 64'(rdata_o), 64'd0);
    chk("R1 strobe A low", 64'(strb_a_o), 64'd0);
    chk("R1 strobe A_n high", 64'(strb_a_n_o), 64'd1);
    chk("R1 strobe B low", 64'(strb_b_o), 64'd0);
    chk("R1 strobe B_n high", 64'(strb_b_n_o), 64'd1);
    rst_n = 1'b1;
    idle(2);

    // R4 aligned write, then R2/R3 read back
    wr_burst('h010, 4, 1);
    idle(2);
    rd_burst('h010, "R2/R4 aligned");
    idle(6);

    // R3 wrap: write from low bits 2, read from aligned base
    wr_burst('h022, 4, 7);
    idle(2);
    rd_burst('h020, "R3 wrap");
    idle(6);

    // R3 top of space: upper bits must not carry
    wr_burst('h3FF, 4, 11);
    idle(2);
    rd_burst('h3FD, "R3 upper fixed");
    idle(6);

    // R6 back-to-back reads: strobes step on every beat
    rd_burst('h010, "R6 back-to-back a");
    idle(3);
    rd_burst('h022, "R6 back-to-back b");
    idle(6);

    // R7 forward from holding register after a full write burst
    wr_burst('h040, 4, 21);
    rd_burst('h043, "R7 forward tail");
    idle(6);

    // R8 + R7: prefill, then a read restart aborts a write burst after 3 beats
    wr_burst('h050, 4, 31);
    idle(2);
    wr_burst('h050, 3, 41);
    rd_burst('h052, "R7/R8 restart");
    idle(6);
    rd_burst('h050, "R8 aborted beat untouched");
    idle(6);

    // R9 reset during a read burst, then array still holds data
    rd_burst('h010, "R9 dropped");
    rst_n = 1'b0;
    exp_q.delete();
    exp_strb = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(6);
    rd_burst('h010, "R9 array kept");
    idle(8);

    chk("R2 all beats delivered", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule